// File: doc/BRIEF.md
# Bridge Driver Standby and Fault Supervisor

This block is the digital supervisor beside a two-channel DC motor bridge. It watches the four direction inputs, two per channel. When all four stay low for longer than a set idle window, it puts the driver into a low-power sleep state. In that state no bridge may drive. The first direction input that goes high wakes the driver. Drive then stays blocked for a settle window while the internal gate supply recovers. The same settle window also applies after power-on reset.

Each channel has a short-circuit detector. A short detected on a channel latches a fault for that channel alone and removes its enable. The latch is cleared only by waking from sleep or by power-on reset. Two digital comparator flags, supply-undervoltage and over-temperature, already carry hysteresis. While either flag is high, both channels are gated off. Nothing is latched for these flags, and drive returns as soon as both flags drop.

All timing is counted in ticks of a prescaler on the system clock. The tick length, the idle window and the settle window are parameters.

Top module: `motsup_top`

## Requirements
- R1: While porN is low, standby, chanEn and ocpFault are all 0.
- R2: After reset is released, chanEn stays 0 until WAKE_TICKS prescaler ticks have elapsed. When TICK_DIV is a multiple of the clock, both channels enable at clock edge WAKE_TICKS*TICK_DIV+1.
- R3: standby rises only after all direction inputs have been low for more than STBY_TICKS ticks. This is later than STBY_TICKS*TICK_DIV clock edges and no later than (STBY_TICKS+1)*TICK_DIV clock edges.
- R4: Any direction input that is high at a clock edge restarts the idle window from zero.
- R5: While standby is 1, chanEn is 0 on both channels.
- R6: In sleep, any direction input high leaves sleep at the next edge. Drive is then held off for WAKE_TICKS ticks: chanEn is 0 at edge (WAKE_TICKS-1)*TICK_DIV+2 after wake and 1 by edge WAKE_TICKS*TICK_DIV+2.
- R7: When ocpFlag[i] is high at an edge while the driver runs, ocpFault[i] is set and chanEn[i] is cleared at that edge. The other channel is unaffected.
- R8: A latched ocpFault[i] stays set after its flag drops, including through sleep. It is cleared at the edge that leaves sleep.
- R9: ocpFlag has no effect while in sleep or during the settle window.
- R10: When uvloFlag or otFlag is high at an edge, both chanEn bits are 0 after that edge and no fault is latched. Drive resumes at the first edge with both flags low, with no settle window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| dirIn | input | 2*NUM_CH | Direction inputs, bits [2i+1:2i] belong to channel i |
| ocpFlag | input | NUM_CH | Per-channel short detected |
| uvloFlag | input | 1 | Load supply below undervoltage threshold (hysteresis upstream) |
| otFlag | input | 1 | Die over temperature (hysteresis upstream) |
| chanEn | output | NUM_CH | Per-channel bridge drive permitted |
| standby | output | 1 | Low-power sleep active |
| ocpFault | output | NUM_CH | Per-channel latched short fault |

## Verification
The bench targets the two edges of the idle window. An off-by-one design would sleep after exactly STBY_TICKS ticks or too late. A single-cycle input pulse just before expiry must restart the window, or the driver sleeps mid-command. Shorts reported during sleep and settle must be ignored, or the driver wakes with a stale fault. A latched fault must survive flag removal and sleep entry and clear only on wake, or it either vanishes on its own or sticks forever. Random stretches of run-time traffic mix short, undervoltage and over-temperature flags against a model. The model catches supply gating that latches a fault, and per-channel faults that leak to the other channel.

// File: rtl/motsup_pkg.sv
package motsup_pkg;

  typedef enum logic [1:0] {
    SUP_WAKE  = 2'd0,
    SUP_RUN   = 2'd1,
    SUP_SLEEP = 2'd2
  } supState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idleRun;    // count idle window
    logic settleRun;  // count settle window
    logic faultArm;   // short flags may latch
    logic faultClr;   // clear fault latches
    logic driveOk;    // next state permits drive
  } supStrobe_t;

endpackage

// File: rtl/motsup_ctrl.sv
module motsup_ctrl
  import motsup_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       anyDir,
  input  logic       idleDone,
  input  logic       settleDone,
  output supStrobe_t strb,
  output logic       standby
);

  supState_t state, stateNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= SUP_WAKE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      SUP_WAKE: begin
        strb.settleRun = 1'b1;
        if (settleDone) stateNext = SUP_RUN;
      end
      SUP_RUN: begin
        strb.idleRun  = 1'b1;
        strb.faultArm = 1'b1;
        if (idleDone) stateNext = SUP_SLEEP;
      end
      SUP_SLEEP: begin
        if (anyDir) begin
          stateNext     = SUP_WAKE;
          strb.faultClr = 1'b1;
        end
      end
      default: stateNext = SUP_WAKE;
    endcase
    strb.driveOk = (stateNext == SUP_RUN);
  end

  assign standby = (state == SUP_SLEEP);

endmodule

// File: rtl/motsup_dp.sv
module motsup_dp
  import motsup_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int TICK_DIV   = 100,
  parameter int STBY_TICKS = 1000,
  parameter int WAKE_TICKS = 200
) (
  input  logic              clk,
  input  logic              porN,
  input  supStrobe_t        strb,
  input  logic              anyDir,
  input  logic [NUM_CH-1:0] ocpFlag,
  input  logic              supplyBad,
  output logic              idleDone,
  output logic              settleDone,
  output logic [NUM_CH-1:0] chanEn,
  output logic [NUM_CH-1:0] ocpFault
);

  localparam int TW = $clog2(TICK_DIV + 1);
  localparam int IW = $clog2(STBY_TICKS + 1);
  localparam int SW = $clog2(WAKE_TICKS + 1);
  localparam logic [TW-1:0] TICK_MAX   = TW'(TICK_DIV - 1);
  localparam logic [IW-1:0] IDLE_MAX   = IW'(STBY_TICKS);
  localparam logic [SW-1:0] SETTLE_MAX = SW'(WAKE_TICKS);

  logic [TW-1:0] tickCnt;
  logic [IW-1:0] idleCnt;
  logic [SW-1:0] settleCnt;
  logic          tick;

  // free-running prescaler
  assign tick = (tickCnt == TICK_MAX);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)     tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else           tickCnt <= tickCnt + 1'b1;
  end

  // idle window: restarts on any direction bit
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                         idleCnt <= '0;
    else if (!strb.idleRun || anyDir)  idleCnt <= '0;
    else if (tick && idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
  end

  assign idleDone = strb.idleRun && !anyDir && tick && (idleCnt == IDLE_MAX);

  // settle window after reset or wake
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                 settleCnt <= '0;
    else if (!strb.settleRun)  settleCnt <= '0;
    else if (tick && settleCnt != SETTLE_MAX) settleCnt <= settleCnt + 1'b1;
  end

  assign settleDone = strb.settleRun && (settleCnt == SETTLE_MAX);

  // per-channel fault latch and enable
  logic [NUM_CH-1:0] faultNext;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign faultNext[ch] = strb.faultClr ? 1'b0
                         : (ocpFault[ch] | (strb.faultArm & ocpFlag[ch]));

    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        ocpFault[ch] <= 1'b0;
        chanEn[ch]   <= 1'b0;
      end else begin
        ocpFault[ch] <= faultNext[ch];
        chanEn[ch]   <= strb.driveOk & ~faultNext[ch] & ~supplyBad;
      end
    end
  end

endmodule

// File: rtl/motsup_top.sv
module motsup_top
  import motsup_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int TICK_DIV   = 100,
  parameter int STBY_TICKS = 1000,
  parameter int WAKE_TICKS = 200
) (
  input  logic                clk,
  input  logic                porN,
  input  logic [2*NUM_CH-1:0] dirIn,
  input  logic [NUM_CH-1:0]   ocpFlag,
  input  logic                uvloFlag,
  input  logic                otFlag,
  output logic [NUM_CH-1:0]   chanEn,
  output logic                standby,
  output logic [NUM_CH-1:0]   ocpFault
);

  supStrobe_t strb;
  logic       anyDir;
  logic       idleDone;
  logic       settleDone;

  assign anyDir = |dirIn;

  motsup_ctrl u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .anyDir     (anyDir),
    .idleDone   (idleDone),
    .settleDone (settleDone),
    .strb       (strb),
    .standby    (standby)
  );

  motsup_dp #(
    .NUM_CH     (NUM_CH),
    .TICK_DIV   (TICK_DIV),
    .STBY_TICKS (STBY_TICKS),
    .WAKE_TICKS (WAKE_TICKS)
  ) u_dp (
    .clk        (clk),
    .porN       (porN),
    .strb       (strb),
    .anyDir     (anyDir),
    .ocpFlag    (ocpFlag),
    .supplyBad  (uvloFlag | otFlag),
    .idleDone   (idleDone),
    .settleDone (settleDone),
    .chanEn     (chanEn),
    .ocpFault   (ocpFault)
  );

endmodule

// File: rtl/motsup_chk.sv
module motsup_chk #(
  parameter int NUM_CH = 2
) (
  input logic                clk,
  input logic                porN,
  input logic [2*NUM_CH-1:0] dirIn,
  input logic [NUM_CH-1:0]   ocpFlag,
  input logic                uvloFlag,
  input logic                otFlag,
  input logic [NUM_CH-1:0]   chanEn,
  input logic                standby,
  input logic [NUM_CH-1:0]   ocpFault
);

  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!porN)
    $rose(standby) |-> $past(dirIn) == '0);

  p_sleep_no_drive_r5: assert property (@(posedge clk) disable iff (!porN)
    standby |-> chanEn == '0);

  p_wake_exit_r6: assert property (@(posedge clk) disable iff (!porN)
    (standby && dirIn != '0) |=> (!standby && chanEn == '0 && ocpFault == '0));

  p_supply_gate_r10: assert property (@(posedge clk) disable iff (!porN)
    (uvloFlag || otFlag) |=> chanEn == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_fault_blocks_r7: assert property (@(posedge clk) disable iff (!porN)
      ocpFault[i] |-> !chanEn[i]);

    p_fault_hold_r8: assert property (@(posedge clk) disable iff (!porN)
      (ocpFault[i] && !(standby && dirIn != '0)) |=> ocpFault[i]);

    p_sleep_ignore_r9: assert property (@(posedge clk) disable iff (!porN)
      (standby && !ocpFault[i]) |=> !ocpFault[i]);
  end

endmodule

bind motsup_top motsup_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .porN     (porN),
  .dirIn    (dirIn),
  .ocpFlag  (ocpFlag),
  .uvloFlag (uvloFlag),
  .otFlag   (otFlag),
  .chanEn   (chanEn),
  .standby  (standby),
  .ocpFault (ocpFault)
);

// File: tb/motsup_top_test.sv
module motsup_top_test;

  localparam int D = 3;   // clocks per tick
  localparam int S = 10;  // idle ticks
  localparam int W = 5;   // settle ticks

  logic       clk = 1'b0;
  logic       porN;
  logic [3:0] dirIn;
  logic [1:0] ocpFlag;
  logic       uvloFlag;
  logic       otFlag;
  logic [1:0] chanEn;
  logic       standby;
  logic [1:0] ocpFault;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  motsup_top #(
    .NUM_CH(2), .TICK_DIV(D), .STBY_TICKS(S), .WAKE_TICKS(W)
  ) uut (
    .clk(clk), .porN(porN), .dirIn(dirIn), .ocpFlag(ocpFlag),
    .uvloFlag(uvloFlag), .otFlag(otFlag),
    .chanEn(chanEn), .standby(standby), .ocpFault(ocpFault)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // model of run-time enables
  function automatic logic [1:0] expEn(input logic [1:0] flt, input logic u, input logic t);
    return (u || t) ? 2'b00 : ~flt;
  endfunction

  task automatic sleepAndWake();
    dirIn = 4'b0000; ocpFlag = 2'b00; uvloFlag = 1'b0; otFlag = 1'b0;
    step((S + 1) * D);
    chk("R3 sleep entered", {7'd0, standby}, 8'd1);
    dirIn = 4'b1000;
    step(1);
    chk("R6 wake", {7'd0, standby}, 8'd0);
    chk("R8 fault cleared on wake", {6'd0, ocpFault}, 8'd0);
    step(W * D + 1);
    chk("R6 drive after settle", {6'd0, chanEn}, 8'h3);
  endtask

  initial begin
    int seed;
    logic [1:0] mFault;
    seed = $urandom(32'h5EED_0042);
    porN = 1'b0; dirIn = 4'b0; ocpFlag = 2'b0; uvloFlag = 1'b0; otFlag = 1'b0;
    step(3);
    chk("R1 standby in reset", {7'd0, standby}, 8'd0);
    chk("R1 chanEn in reset", {6'd0, chanEn}, 8'd0);
    chk("R1 fault in reset", {6'd0, ocpFault}, 8'd0);

    // R2 power-up settle
    dirIn = 4'b0001;
    porN  = 1'b1;
    step(W * D);
    chk("R2 held off", {6'd0, chanEn}, 8'd0);
    step(1);
    chk("R2 enabled", {6'd0, chanEn}, 8'h3);

    // R3 / R4 idle window with restart pulse
    dirIn = 4'b0000;
    step(S * D);
    chk("R3 not yet", {7'd0, standby}, 8'd0);
    dirIn = 4'b0010;
    step(1);
    dirIn = 4'b0000;
    step(S * D);
    chk("R4 window restarted", {7'd0, standby}, 8'd0);
    step(D);
    chk("R3 standby", {7'd0, standby}, 8'd1);
    chk("R5 no drive in sleep", {6'd0, chanEn}, 8'd0);

    // R9 shorts in sleep and settle ignored
    ocpFlag = 2'b11;
    step(3);
    chk("R9 ignored in sleep", {6'd0, ocpFault}, 8'd0);
    ocpFlag = 2'b00;
    dirIn = 4'b0100;
    step(1);
    chk("R6 left sleep", {7'd0, standby}, 8'd0);
    ocpFlag = 2'b11;
    step(2);
    ocpFlag = 2'b00;
    step((W - 1) * D + 2 - 3);
    chk("R6 settle holds drive off", {6'd0, chanEn}, 8'd0);
    step(D);
    chk("R6 drive after settle", {6'd0, chanEn}, 8'h3);
    chk("R9 no fault from settle", {6'd0, ocpFault}, 8'd0);

    // R7 / R8 per-channel latch
    ocpFlag = 2'b01;
    step(1);
    chk("R7 fault ch0", {6'd0, ocpFault}, 8'h1);
    chk("R7 ch0 off ch1 on", {6'd0, chanEn}, 8'h2);
    ocpFlag = 2'b00;
    step(3);
    chk("R8 fault holds", {6'd0, ocpFault}, 8'h1);

    // R10 supply gating
    uvloFlag = 1'b1;
    step(1);
    chk("R10 uvlo gates", {6'd0, chanEn}, 8'd0);
    chk("R10 no latch", {6'd0, ocpFault}, 8'h1);
    uvloFlag = 1'b0;
    step(1);
    chk("R10 resume", {6'd0, chanEn}, 8'h2);
    otFlag = 1'b1;
    step(1);
    chk("R10 ot gates", {6'd0, chanEn}, 8'd0);
    otFlag = 1'b0;

    // R8 fault survives sleep, clears on wake
    dirIn = 4'b0000;
    step((S + 1) * D);
    chk("R8 fault visible in sleep", {6'd0, ocpFault}, 8'h1);
    dirIn = 4'b0001;
    step(1);
    chk("R8 cleared on wake", {6'd0, ocpFault}, 8'd0);
    step(W * D + 1);
    chk("R6 enabled again", {6'd0, chanEn}, 8'h3);

    // random run-time traffic against model (R7 R8 R10)
    for (int round = 0; round < 3; round++) begin
      mFault = 2'b00;
      for (int c = 0; c < 250; c++) begin
        dirIn    = 4'($urandom % 15 + 1);
        ocpFlag  = {($urandom % 40) == 0, ($urandom % 40) == 0};
        uvloFlag = ($urandom % 6) == 0;
        otFlag   = ($urandom % 8) == 0;
        step(1);
        mFault = mFault | ocpFlag;
        chk("R7 random fault", {6'd0, ocpFault}, {6'd0, mFault});
        chk("R10 random enable", {6'd0, chanEn}, {6'd0, expEn(mFault, uvloFlag, otFlag)});
      end
      chk("R4 random no sleep", {7'd0, standby}, 8'd0);
      sleepAndWake();
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule